// File: doc/BRIEF.md
# Collision Heartbeat Pulse Generator

This block produces the self-test burst that a coaxial transceiver puts on its collision line after every transmission. The host uses the burst to confirm that the collision path works. The block watches the transmit-active input for its high-to-low transition. It then waits a fixed number of clock cycles and opens a heartbeat window of fixed length. While the window is open, a square tone derived from the system clock is driven onto the collision output.

The same gated tone also carries real collision requests and jabber-fault requests. The collision output is therefore one signal fed by three sources, and it rests at a steady zero when none of them is active. The heartbeat can be switched off for use behind repeaters. The enable is sampled at the moment transmission ends, so a change made during a pending or running burst has no effect on it. A new transmission that starts while a heartbeat is pending or running cancels that heartbeat.

The delay, the window length and the tone divide ratio are parameters. With a 100 MHz clock, the default values give a 1.1 ms delay, a 1 ms window and a 10 MHz tone.

Top module: `collision_heartbeat`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, and in the first cycle after it is released with all requests low, `hbActive` and `collisionOut` are 0.
- R2: A transmit end is a rising clock edge at which `txActive` is 0 after being 1 at the previous edge. If `hbEnable` is 1 at that edge, `hbActive` goes to 1 exactly DELAY_CYCLES clock edges later.
- R3: Once `hbActive` has risen, it stays 1 for exactly WINDOW_CYCLES clock cycles and then returns to 0, provided no new transmission starts.
- R4: If `hbEnable` is 0 at the transmit-end edge, no heartbeat window follows that transmission.
- R5: Changes to `hbEnable` after the transmit-end edge do not shorten, cancel or start a heartbeat. Only its value at the transmit-end edge counts.
- R6: If `txActive` is 1 at any edge while a heartbeat is pending or running, the heartbeat is cancelled. `hbActive` is 0 after that edge.
- R7: The tone runs freely from reset with a period of TONE_DIV cycles. It is high during the first TONE_DIV/2 cycles of each period, counted from the first edge after reset is released.
- R8: `collisionOut` equals the tone ANDed with the OR of `collisionReq`, `jabberReq` and `hbActive`. It is 0 whenever all three are 0.
- R9: A transmit end that follows a cancelled heartbeat starts a new heartbeat with the full DELAY_CYCLES delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txActive | input | 1 | High while the transmitter is sending |
| hbEnable | input | 1 | Heartbeat enable, sampled at transmit end |
| collisionReq | input | 1 | Real collision request |
| jabberReq | input | 1 | Jabber fault request |
| collisionOut | output | 1 | Gated tone for the collision line |
| hbActive | output | 1 | High during the heartbeat window |

## Verification
The bench builds the block with TONE_DIV=4, DELAY_CYCLES=20 and WINDOW_CYCLES=12. With these values, a whole delay-plus-window sequence fits in a few dozen cycles, so one run can cover cancellation inside the delay, cancellation inside the burst, enable changes in both phases and restart after a cancel. The short tone period gives many tone edges inside every window, so the bench can check gating, phase and the idle-zero state of the output cycle by cycle.

// File: rtl/heartbeat_pkg.sv
package heartbeat_pkg;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_BURST = 2'd2
  } hbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;   // restart the phase counter at zero
    logic cntEnable;  // advance the phase counter
    logic selWindow;  // compare against the window length instead of the delay
  } hbStrobes_t;

endpackage

// File: rtl/hb_datapath.sv
module hb_datapath
  import heartbeat_pkg::*;
#(
  parameter int TONE_DIV      = 10,
  parameter int DELAY_CYCLES  = 110000,
  parameter int WINDOW_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  hbStrobes_t strobes,
  input  logic       collisionReq,
  input  logic       jabberReq,
  input  logic       hbActive,
  output logic       cntLast,
  output logic       collisionOut
);

  localparam int MAX_CNT = (DELAY_CYCLES > WINDOW_CYCLES) ? DELAY_CYCLES : WINDOW_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam int TONE_W  = (TONE_DIV > 1) ? $clog2(TONE_DIV) : 1;
  localparam int HALF    = TONE_DIV / 2;

  logic [CNT_W-1:0]  phaseCnt;
  logic [CNT_W-1:0]  limitSel;
  logic [TONE_W-1:0] toneCnt;
  logic              toneLevel;
  logic              gateOn;

  // phase counter shared by the delay and the window
  assign limitSel = strobes.selWindow ? CNT_W'(WINDOW_CYCLES - 1) : CNT_W'(DELAY_CYCLES - 1);
  assign cntLast  = (phaseCnt == limitSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (strobes.cntClear) begin
      phaseCnt <= '0;
    end else if (strobes.cntEnable) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  // free-running tone divider
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toneCnt <= '0;
    end else if (toneCnt == TONE_W'(TONE_DIV - 1)) begin
      toneCnt <= '0;
    end else begin
      toneCnt <= toneCnt + 1'b1;
    end
  end

  assign toneLevel    = (toneCnt < TONE_W'(HALF));
  assign gateOn       = collisionReq | jabberReq | hbActive;
  assign collisionOut = gateOn & toneLevel;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntEnable |-> (phaseCnt < limitSel)); // R3

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(collisionReq || jabberReq || hbActive) |-> !collisionOut); // R8

endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import heartbeat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txActive,
  input  logic       hbEnable,
  input  logic       cntLast,
  output hbStrobes_t strobes,
  output logic       hbActive
);

  hbState_t state, stateNext;
  logic     txPrev;
  logic     txFall;

  assign txFall = txPrev & ~txActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= HB_IDLE;
      txPrev <= 1'b0;
    end else begin
      state  <= stateNext;
      txPrev <= txActive;
    end
  end

  always_comb begin
    stateNext         = state;
    strobes.cntClear  = 1'b0;
    strobes.cntEnable = 1'b0;
    strobes.selWindow = (state == HB_BURST);
    unique case (state)
      HB_IDLE: begin
        if (txFall && hbEnable) begin
          stateNext        = HB_WAIT;
          strobes.cntClear = 1'b1;
        end
      end
      HB_WAIT: begin
        if (txActive) begin
          stateNext = HB_IDLE;
        end else if (cntLast) begin
          stateNext        = HB_BURST;
          strobes.cntClear = 1'b1;
        end else begin
          strobes.cntEnable = 1'b1;
        end
      end
      HB_BURST: begin
        if (txActive || cntLast) begin
          stateNext = HB_IDLE;
        end else begin
          strobes.cntEnable = 1'b1;
        end
      end
      default: stateNext = HB_IDLE;
    endcase
  end

  assign hbActive = (state == HB_BURST);

  AST_CANCEL_ON_TX: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && state != HB_IDLE) |=> (state == HB_IDLE)); // R6

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    (state == HB_IDLE && txFall && !hbEnable) |=> (state == HB_IDLE)); // R4

  AST_BURST_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == HB_BURST) |-> ($past(state) == HB_WAIT)); // R2

  AST_WAIT_FROM_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == HB_WAIT) |-> $past(txFall && hbEnable)); // R5

endmodule

// File: rtl/collision_heartbeat.sv
module collision_heartbeat
  import heartbeat_pkg::*;
#(
  parameter int TONE_DIV      = 10,
  parameter int DELAY_CYCLES  = 110000,
  parameter int WINDOW_CYCLES = 100000
) (
  input  logic clk,
  input  logic rstN,
  input  logic txActive,
  input  logic hbEnable,
  input  logic collisionReq,
  input  logic jabberReq,
  output logic collisionOut,
  output logic hbActive
);

  hbStrobes_t strobes;
  logic       cntLast;

  hb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .txActive (txActive),
    .hbEnable (hbEnable),
    .cntLast  (cntLast),
    .strobes  (strobes),
    .hbActive (hbActive)
  );

  hb_datapath #(
    .TONE_DIV      (TONE_DIV),
    .DELAY_CYCLES  (DELAY_CYCLES),
    .WINDOW_CYCLES (WINDOW_CYCLES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .collisionReq (collisionReq),
    .jabberReq    (jabberReq),
    .hbActive     (hbActive),
    .cntLast      (cntLast),
    .collisionOut (collisionOut)
  );

endmodule

// File: tb/collision_heartbeat_tb_top.sv
`timescale 1ns/1ps
module collision_heartbeat_tb_top;

  localparam int TD = 4;
  localparam int DL = 20;
  localparam int WN = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txActive = 1'b0;
  logic hbEnable = 1'b1;
  logic collisionReq = 1'b0;
  logic jabberReq = 1'b0;
  logic collisionOut;
  logic hbActive;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  int  mCycle = 0;
  bit  mPrev = 0;
  int  mPhase = 0;   // 0 idle, 1 waiting, 2 window
  int  mRemain = 0;
  bit  expHb, expOut;

  always #4 clk = ~clk;

  collision_heartbeat #(.TONE_DIV(TD), .DELAY_CYCLES(DL), .WINDOW_CYCLES(WN)) dut_i (
    .clk(clk), .rstN(rstN), .txActive(txActive), .hbEnable(hbEnable),
    .collisionReq(collisionReq), .jabberReq(jabberReq),
    .collisionOut(collisionOut), .hbActive(hbActive)
  );

  task automatic check(input string req, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mCycle = 0; mPrev = 0; mPhase = 0; mRemain = 0;
    end else begin
      mCycle++;
      if (mPhase != 0 && txActive) begin
        mPhase = 0;                          // R6 cancel
      end else if (mPhase == 1) begin
        mRemain--;
        if (mRemain == 0) begin mPhase = 2; mRemain = WN; end
      end else if (mPhase == 2) begin
        mRemain--;
        if (mRemain == 0) mPhase = 0;
      end else if (mPrev && !txActive && hbEnable) begin
        mPhase = 1; mRemain = DL;
      end
      mPrev = txActive;
    end
    #2;
    expHb  = (mPhase == 2);
    expOut = (collisionReq || jabberReq || expHb) && ((mCycle % TD) < TD / 2);
    check(curReq, hbActive, expHb, "hbActive");
    check((collisionReq || jabberReq) ? "R8" : curReq, collisionOut, expOut, "collisionOut");
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic txPulse(input int len);
    txActive = 1'b1; cyc(len); txActive = 1'b0;
  endtask

  initial begin
    cyc(3);
    check("R1", hbActive, 1'b0, "hbActive in reset");
    check("R1", collisionOut, 1'b0, "collisionOut in reset");
    rstN = 1'b1;
    cyc(3);
    curReq = "R7"; collisionReq = 1'b1; cyc(9); collisionReq = 1'b0;
    jabberReq = 1'b1; cyc(7); jabberReq = 1'b0; cyc(2);
    curReq = "R2"; txPulse(5); cyc(DL - 1);
    curReq = "R3"; cyc(WN + 6);
    curReq = "R4"; hbEnable = 1'b0; txPulse(4); cyc(DL + WN + 5); hbEnable = 1'b1;
    curReq = "R5"; txPulse(3); cyc(5); hbEnable = 1'b0; cyc(DL); cyc(WN + 4);
    hbEnable = 1'b1; txPulse(3); cyc(DL + 3); hbEnable = 1'b0; cyc(WN + 3);
    hbEnable = 1'b0; txPulse(3); cyc(4); hbEnable = 1'b1; cyc(DL + WN + 4);
    curReq = "R6"; txPulse(3); cyc(8); txActive = 1'b1; cyc(2);
    curReq = "R9"; txActive = 1'b0; cyc(DL + WN + 4);
    curReq = "R6"; txPulse(2); cyc(DL + 4); txActive = 1'b1; cyc(1); txActive = 1'b0;
    cyc(DL + WN + 4);
    curReq = "R8"; txPulse(2); cyc(DL + 2); collisionReq = 1'b1; cyc(5); collisionReq = 1'b0;
    cyc(WN + 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20000 * 8);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule